// File: doc/BRIEF.md
# Sample FIFO with Block Interrupts

This block sits between an ADC sample stream and a host that pulls data out as whole 16-bit words. Samples are stored in a first-in first-out buffer of `DEPTH` entries. The host is told when to read in one of two ways. In single-sample mode every stored sample raises an interrupt event. In paced mode an event fires only when the buffer level climbs to half its depth, which is the point for a block transfer of `DEPTH/2` words.

When the total sample count is not a whole number of blocks, the last partial block would never raise an event. A residual counter covers this tail. Software loads it with the remainder, then opens its gate. After the next block event, every conversion counts the residual counter down, and the conversion that reaches terminal count raises one final event. The residual controller is a four-state machine:
- `RS_IDLE`: moves to `RS_ARMED` when enhanced mode and the gate are both set.
- `RS_ARMED`: on a block event, moves to `RS_COUNT` if the counter is nonzero, or to `RS_DONE` if it is zero.
- `RS_COUNT`: moves to `RS_DONE` on the conversion that finds the counter at 1 (or 0), raising the final event.
- `RS_DONE`: waits.

Every state returns to `RS_IDLE` when enhanced mode or the gate is dropped.

Status is kept in latched flags: an overrun flag, an interrupt flag, and a live empty indication.

Top module: `sample_fifo_irq`

## Requirements
- R1: Stored samples come out in the order they were written. The buffer holds exactly `DEPTH` samples (`DEPTH` a power of two).
- R2: `rd_data` changes on the clock edge that accepts a read, so it is valid one cycle after `rd_en`. A read while the buffer is empty leaves `rd_data` at the last word read and stores nothing.
- R3: A sample offered while the buffer holds `DEPTH` words is dropped, even if a read happens in the same cycle, and `ovr_flag` goes to 1. The flag stays at 1 until a scan-range write.
- R4: `scan_wr` empties the buffer and clears `ovr_flag`. A sample or read in that same cycle has no effect on the buffer.
- R5: `fifo_empty` is 1 when the buffer holds no words and 0 when it holds at least one.
- R6: With `pace_sel`=0 (single-sample mode), every sample accepted into the buffer is an interrupt event.
- R7: With `pace_sel`=1 (paced mode), an interrupt event fires only on the accepted write that raises the level from `DEPTH/2-1` to `DEPTH/2` with no read in the same cycle. Further writes above that level raise no event.
- R8: `irq_flag` is set by an event and stays set until a `stat_wr` pulse. If an event and `stat_wr` fall in the same cycle, the flag ends up set.
- R9: When `irq_sel` is 4'b0000, no event sets `irq_flag`. Any nonzero value enables events.
- R10: With `enh_mode` and `res_gate` both high, the first block event after arming starts the countdown. From then on, every `smp_valid` cycle decrements the residual counter. The cycle that finds it at 1 raises the final event. A counter of 0 at the block event gives no extra event.
- R11: Dropping `enh_mode` or `res_gate` returns the residual controller to `RS_IDLE`. Re-arming then needs a new block event before any countdown.
- R12: `res_load` writes `res_value` into the residual counter in any state. The load takes priority over a decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A conversion result is offered this cycle |
| smp_data | input | DATA_W | Conversion result |
| rd_en | input | 1 | Host word read |
| scan_wr | input | 1 | Scan-range write: empties buffer, clears overrun |
| stat_wr | input | 1 | Status write: clears interrupt flag |
| pace_sel | input | 1 | 0 = single-sample events, 1 = half-depth block events |
| irq_sel | input | 4 | Interrupt select, zero disables |
| enh_mode | input | 1 | Residual counter takes over the counter function |
| res_gate | input | 1 | Residual counter gate |
| res_load | input | 1 | Load residual counter |
| res_value | input | RES_W | Residual count to load |
| rd_data | output | DATA_W | Word returned by the last accepted read |
| fifo_empty | output | 1 | 1 when the buffer holds no words |
| ovr_flag | output | 1 | Latched overrun |
| irq_flag | output | 1 | Latched interrupt |

## Verification
The bench builds the block with `DEPTH`=16 and `RES_W`=8, so a block event comes after eight writes and a full buffer after sixteen. Because of this, overrun, post-overrun drain, repeated half-level crossings and complete residual countdowns all fit into a short run. A random phase then alternates write-heavy and read-heavy stretches with sparse clears and mode changes. This makes the buffer cross the half level and wrap its pointers many times while the reference model follows every cycle.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_ARMED = 2'd1,
        RS_COUNT = 2'd2,
        RS_DONE  = 2'd3
    } res_state_e;

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_req,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_req,
    output logic [DATA_W-1:0]        rd_data,
    output logic [$clog2(DEPTH):0]   level,
    output logic                     empty,
    output logic                     wr_ok,
    output logic                     rd_ok,
    output logic                     ovr
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp;
    logic [AW-1:0]     rp;
    logic              full;

    assign full  = (level == FULL_LVL);
    assign empty = (level == '0);
    assign wr_ok = wr_req & ~full & ~clr;
    assign rd_ok = rd_req & ~empty & ~clr;

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wp] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp      <= '0;
            rp      <= '0;
            level   <= '0;
            ovr     <= 1'b0;
            rd_data <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
            ovr   <= 1'b0;
        end else begin
            if (wr_ok) begin
                wp <= wp + 1'b1;
            end
            if (rd_ok) begin
                rp      <= rp + 1'b1;
                rd_data <= mem[rp];
            end
            unique case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (wr_req && full) begin
                ovr <= 1'b1;
            end
        end
    end

    // R1: level never exceeds capacity
    a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);

    // R3: write into full buffer leaves level unchanged and flags overrun
    a_r3_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && !rd_req && !clr) |=> (level == $past(level)) && ovr);

    // R3: overrun is sticky until clear
    a_r3_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !clr) |=> ovr);

    // R4: clear empties the buffer and drops overrun
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (level == '0) && !ovr);

    // R2: read of an empty buffer keeps the returned word
    a_r2_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty) |=> $stable(rd_data));

endmodule

// File: rtl/sfifo_residual.sv
module sfifo_residual
    import sfifo_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             conv,
    input  logic             blk_evt,
    input  logic             load,
    input  logic [RES_W-1:0] load_val,
    output logic             tc_evt
);
    localparam logic [RES_W-1:0] ONE = RES_W'(1);

    res_state_e       st;
    res_state_e       st_nx;
    logic [RES_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == '0) || (cnt == ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= RS_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        tc_evt = 1'b0;
        unique case (st)
            RS_IDLE: begin
                if (enable) st_nx = RS_ARMED;
            end
            RS_ARMED: begin
                if (!enable)      st_nx = RS_IDLE;
                else if (blk_evt) st_nx = (cnt == '0) ? RS_DONE : RS_COUNT;
            end
            RS_COUNT: begin
                if (!enable) begin
                    st_nx = RS_IDLE;
                end else if (conv && at_end) begin
                    tc_evt = 1'b1;
                    st_nx  = RS_DONE;
                end
            end
            RS_DONE: begin
                if (!enable) st_nx = RS_IDLE;
            end
            default: st_nx = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (st == RS_COUNT && enable && conv && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R10: the final event always ends the countdown
    a_r10_tc_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        tc_evt |=> (st == RS_DONE));

    // R11: losing enable always returns to idle
    a_r11_off_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st == RS_IDLE));

    // R12: a load is visible on the next cycle
    a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/sfifo_irq_gen.sv
module sfifo_irq_gen #(
    parameter int DEPTH = 1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   paced,
    input  logic                   wr_ok,
    input  logic                   rd_ok,
    input  logic [$clog2(DEPTH):0] level,
    input  logic                   tc_evt,
    input  logic                   stat_clr,
    input  logic [3:0]             sel,
    output logic                   blk_evt,
    output logic                   irq_flag
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] PRE_HALF = CW'(DEPTH / 2 - 1);

    logic sw_evt;
    logic any_evt;
    logic sel_on;

    assign blk_evt = paced & wr_ok & ~rd_ok & (level == PRE_HALF);
    assign sw_evt  = ~paced & wr_ok;
    assign any_evt = sw_evt | blk_evt | tc_evt;
    assign sel_on  = |sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
        end else if (any_evt && sel_on) begin
            irq_flag <= 1'b1;
        end else if (stat_clr) begin
            irq_flag <= 1'b0;
        end
    end

    // R9: a zero select never raises the flag
    a_r9_sel_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 4'b0000 && !irq_flag) |=> !irq_flag);

    // R8: a status write with no event clears the flag
    a_r8_clear_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !any_evt) |=> !irq_flag);

    // R8: flag is latched until cleared
    a_r8_flag_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !stat_clr) |=> irq_flag);

endmodule

// File: rtl/sample_fifo_irq.sv
module sample_fifo_irq #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    parameter int RES_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              rd_en,
    input  logic              scan_wr,
    input  logic              stat_wr,
    input  logic              pace_sel,
    input  logic [3:0]        irq_sel,
    input  logic              enh_mode,
    input  logic              res_gate,
    input  logic              res_load,
    input  logic [RES_W-1:0]  res_value,
    output logic [DATA_W-1:0] rd_data,
    output logic              fifo_empty,
    output logic              ovr_flag,
    output logic              irq_flag
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [CW-1:0] level;
    logic          wr_ok;
    logic          rd_ok;
    logic          blk_evt;
    logic          tc_evt;

    sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (scan_wr),
        .wr_req  (smp_valid),
        .wr_data (smp_data),
        .rd_req  (rd_en),
        .rd_data (rd_data),
        .level   (level),
        .empty   (fifo_empty),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .ovr     (ovr_flag)
    );

    sfifo_irq_gen #(.DEPTH(DEPTH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .paced    (pace_sel),
        .wr_ok    (wr_ok),
        .rd_ok    (rd_ok),
        .level    (level),
        .tc_evt   (tc_evt),
        .stat_clr (stat_wr),
        .sel      (irq_sel),
        .blk_evt  (blk_evt),
        .irq_flag (irq_flag)
    );

    sfifo_residual #(.RES_W(RES_W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enh_mode & res_gate),
        .conv     (smp_valid),
        .blk_evt  (blk_evt),
        .load     (res_load),
        .load_val (res_value),
        .tc_evt   (tc_evt)
    );

    // R6: in single-sample mode a stored sample with select on raises the flag
    a_r6_sample_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!pace_sel && wr_ok && irq_sel != 4'b0000) |=> irq_flag);

    // R5: empty indication tracks accepted traffic
    a_r5_write_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !rd_ok) |=> !fifo_empty);

endmodule

// File: tb/test_sample_fifo_irq.sv
`timescale 1ns/1ps
module test_sample_fifo_irq;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 16;
    localparam int RES_W  = 8;
    localparam int HALF   = DEPTH / 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [DATA_W-1:0] smp_data = '0;
    logic              rd_en = 1'b0;
    logic              scan_wr = 1'b0;
    logic              stat_wr = 1'b0;
    logic              pace_sel = 1'b0;
    logic [3:0]        irq_sel = 4'h0;
    logic              enh_mode = 1'b0;
    logic              res_gate = 1'b0;
    logic              res_load = 1'b0;
    logic [RES_W-1:0]  res_value = '0;
    logic [DATA_W-1:0] rd_data;
    logic              fifo_empty;
    logic              ovr_flag;
    logic              irq_flag;

    int nchk = 0;
    int nerr = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sample_fifo_irq #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RES_W(RES_W)) i_sample_fifo_irq (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .rd_en(rd_en), .scan_wr(scan_wr), .stat_wr(stat_wr), .pace_sel(pace_sel),
        .irq_sel(irq_sel), .enh_mode(enh_mode), .res_gate(res_gate),
        .res_load(res_load), .res_value(res_value), .rd_data(rd_data),
        .fifo_empty(fifo_empty), .ovr_flag(ovr_flag), .irq_flag(irq_flag)
    );

    // behavioural reference model
    logic [DATA_W-1:0] mq[$];
    logic [DATA_W-1:0] m_rd;
    bit m_ovr, m_irq;
    int m_rs;   // 0 idle, 1 armed, 2 counting, 3 done
    int m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mq.delete(); m_rd = '0; m_ovr = 0; m_irq = 0; m_rs = 0; m_cnt = 0;
        end else begin
            int sz;
            bit rok, wok, blk, sw, tc, en;
            sz = mq.size(); rok = 0; wok = 0; tc = 0;
            en = enh_mode && res_gate;
            if (scan_wr) begin
                mq.delete(); m_ovr = 0;
            end else begin
                rok = rd_en && sz > 0;
                wok = smp_valid && sz < DEPTH;
                if (rok) m_rd = mq.pop_front();
                if (wok) mq.push_back(smp_data);
                if (smp_valid && !wok) m_ovr = 1;
            end
            blk = pace_sel && wok && !rok && sz == HALF - 1;
            sw  = !pace_sel && wok;
            case (m_rs)
                0: if (en) m_rs = 1;
                1: if (!en) m_rs = 0; else if (blk) m_rs = (m_cnt == 0) ? 3 : 2;
                2: if (!en) m_rs = 0;
                   else if (smp_valid) begin
                       if (m_cnt <= 1) begin tc = 1; m_rs = 3; end
                       if (!res_load && m_cnt > 0) m_cnt = m_cnt - 1;
                   end
                default: if (!en) m_rs = 0;
            endcase
            if (res_load) m_cnt = res_value;
            if ((sw || blk || tc) && irq_sel != 0) m_irq = 1;
            else if (stat_wr) m_irq = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R1/R2 model rd_data", rd_data, m_rd);
            chk("R5 model fifo_empty", fifo_empty, mq.size() == 0);
            chk("R3 model ovr_flag", ovr_flag, m_ovr);
            chk("R8 model irq_flag", irq_flag, m_irq);
        end
    end

    task automatic tick();
        @(posedge clk); @(negedge clk);
        smp_valid = 0; rd_en = 0; scan_wr = 0; stat_wr = 0; res_load = 0;
    endtask
    task automatic push(input logic [DATA_W-1:0] d);
        smp_valid = 1; smp_data = d; tick();
    endtask
    task automatic pop();
        rd_en = 1; tick();
    endtask
    task automatic scan();
        scan_wr = 1; tick();
    endtask
    task automatic sclr();
        stat_wr = 1; tick();
    endtask
    task automatic load(input int v);
        res_load = 1; res_value = RES_W'(v); tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;
        chk("R5 reset empty", fifo_empty, 1);
        chk("R8 reset irq", irq_flag, 0);
        chk("R3 reset ovr", ovr_flag, 0);
        chk("R2 reset rd_data", rd_data, 0);

        // single-sample mode
        irq_sel = 4'h1; pace_sel = 0;
        push(16'hA001);
        chk("R6 event on write", irq_flag, 1);
        chk("R5 not empty", fifo_empty, 0);
        push(16'hA002); push(16'hA003);
        sclr();
        chk("R8 status clear", irq_flag, 0);
        pop(); chk("R1 order first", rd_data, 16'hA001);
        pop(); chk("R1 order second", rd_data, 16'hA002);
        pop(); chk("R1 order third", rd_data, 16'hA003);
        chk("R5 empty after drain", fifo_empty, 1);
        pop(); chk("R2 empty read holds", rd_data, 16'hA003);
        chk("R2 empty read stores nothing", fifo_empty, 1);
        smp_valid = 1; smp_data = 16'hB000; stat_wr = 1; tick();
        chk("R8 event beats clear", irq_flag, 1);
        pop(); sclr();
        irq_sel = 4'h0;
        push(16'hC000);
        chk("R9 zero select quiet", irq_flag, 0);
        pop(); irq_sel = 4'h9;

        // paced mode, fill and overrun
        pace_sel = 1;
        for (int i = 0; i < HALF - 1; i++) push(16'hD000 + 16'(i));
        chk("R7 no event below half", irq_flag, 0);
        push(16'hD000 + 16'(HALF - 1));
        chk("R7 event at half", irq_flag, 1);
        sclr();
        for (int i = HALF; i < DEPTH; i++) push(16'hD000 + 16'(i));
        chk("R7 single event per crossing", irq_flag, 0);
        chk("R3 no overrun at exactly full", ovr_flag, 0);
        push(16'hEEEE);
        chk("R3 overrun on full write", ovr_flag, 1);
        smp_valid = 1; smp_data = 16'hEEEF; rd_en = 1; tick();
        chk("R3 full write dropped despite read", rd_data, 16'hD000);
        for (int i = 1; i < DEPTH; i++) pop();
        chk("R3 last stored word", rd_data, 16'hD000 + 16'(DEPTH - 1));
        chk("R3 dropped words absent", fifo_empty, 1);
        chk("R3 overrun sticky", ovr_flag, 1);
        scan();
        chk("R4 scan clears overrun", ovr_flag, 0);
        push(16'h1111); push(16'h2222);
        smp_valid = 1; smp_data = 16'h3333; rd_en = 1; scan_wr = 1; tick();
        chk("R4 scan empties", fifo_empty, 1);
        chk("R4 read ignored under scan", rd_data, 16'hD000 + 16'(DEPTH - 1));
        sclr();

        // residual countdown
        load(3); enh_mode = 1; res_gate = 1; tick();
        for (int i = 0; i < HALF; i++) push(16'h4000 + 16'(i));
        chk("R10 block event", irq_flag, 1);
        sclr();
        push(16'h4100); push(16'h4101);
        chk("R10 no early final", irq_flag, 0);
        push(16'h4102);
        chk("R10 final event at terminal count", irq_flag, 1);
        sclr(); push(16'h4103);
        chk("R10 done stays quiet", irq_flag, 0);
        scan();

        // zero residual
        res_gate = 0; tick();
        load(0); res_gate = 1; tick();
        for (int i = 0; i < HALF; i++) push(16'h5000);
        sclr();
        push(1); push(2); push(3);
        chk("R10 zero remainder no extra", irq_flag, 0);
        scan();

        // gate dropped mid-count
        res_gate = 0; tick(); load(5); res_gate = 1; tick();
        for (int i = 0; i < HALF; i++) push(16'h6000);
        sclr(); push(1); push(2);
        res_gate = 0; tick(); res_gate = 1; tick();
        push(3); push(4); push(5);
        chk("R11 disarm cancels countdown", irq_flag, 0);
        scan();

        // reload mid-count
        res_gate = 0; tick(); load(6); res_gate = 1; tick();
        for (int i = 0; i < HALF; i++) push(16'h7000);
        sclr(); push(1);
        load(2);
        push(2);
        chk("R12 reload not yet terminal", irq_flag, 0);
        push(3);
        chk("R12 reload reaches terminal", irq_flag, 1);
        scan(); enh_mode = 0; res_gate = 0; sclr();

        // random traffic against the model
        for (int ph = 0; ph < 40; ph++) begin
            int wp;
            wp = (ph % 2 == 0) ? 80 : 30;
            if ($urandom_range(0, 3) == 0) pace_sel = ~pace_sel;
            if ($urandom_range(0, 4) == 0) irq_sel = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 2) == 0) enh_mode = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 2) == 0) res_gate = 1'($urandom_range(0, 1));
            for (int c = 0; c < 60; c++) begin
                smp_valid = ($urandom_range(0, 99) < wp);
                smp_data  = 16'($urandom);
                rd_en     = ($urandom_range(0, 99) < 100 - wp);
                scan_wr   = ($urandom_range(0, 149) == 0);
                stat_wr   = ($urandom_range(0, 5) == 0);
                res_load  = ($urandom_range(0, 39) == 0);
                res_value = RES_W'($urandom_range(0, 12));
                @(posedge clk); @(negedge clk);
            end
        end
        smp_valid = 0; rd_en = 0; scan_wr = 0; stat_wr = 0; res_load = 0;
        tick();
        finish_run();
    end
endmodule